// File: doc/BRIEF.md
# Masked Watchpoint Comparator Pair

This block holds two watchpoint units. On every clock cycle each unit compares the bus access presented at the block's inputs against its own stored value and mask registers. An access is made of an address, a data word and six control bits. Any compared bit whose mask bit is 1 is a don't-care. A unit only fires when its enable bit is set, and that bit has no mask.

The second unit can be tied to the first in two ways. In sequence (chain) mode, it reports only after the first unit has matched on some earlier access. That memory is held until the clear input is pulsed. In range mode, it reports only while the first unit's raw compare is also true. In both modes the first unit acts purely as a qualifier. The result of the pair is a single registered hit flag.

The debug register bank loads the value and mask registers through a one-cycle write port.

Top module: `wp_pair_match`

## Requirements
- R1: After reset, `hit` is 0, the sequence latch is clear, and every value and mask register of both units is 0. Both units are therefore disabled.
- R2: When `cfg_we` is 1, `cfg_wdata` is written to unit `cfg_unit` at the clock edge.
  - The register is chosen by `cfg_sel`: 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control value (9 bits), 5 control mask (8 bits).
  - Codes 6 and 7 write nothing.
  - A write affects accesses from the next cycle on. An access presented in the same cycle as the write uses the old contents.
- R3: A unit matches when all of the following hold:
  - Its control value bit 8 (enable) is 1.
  - Every unmasked address bit and every unmasked data bit equals its stored value.
  - Every unmasked bit of the access control vector equals control value bits 5:0.
  - The access control vector is {bit5 `acc_ext`, bit4 `acc_priv`, bit3 `acc_is_data`, bits 2:1 `acc_size`, bit0 `acc_write`}.
- R4: A mask bit of 1 makes the corresponding address, data or control bit a don't-care. The enable bit cannot be masked. Control mask bits 7:6 have no effect.
- R5: `hit` is registered: it reflects the access presented in the previous cycle. An access with `acc_valid` low produces no hit and does not set the sequence latch.
- R6: When unit 1's control bit 6 (chain) is 1, unit 1 reports only if the sequence latch is set. The latch is set by a valid access on which unit 0 matched, it takes effect from the following access, and it stays set.
- R7: `seq_clear` clears the sequence latch at the clock edge. It takes priority over a unit 0 match in the same cycle.
- R8: When unit 1's control bit 7 (range) is 1, unit 1 reports only if unit 0's masked compare of address, data and control is also true for the same access. This compare ignores unit 0's enable bit.
- R9: If unit 1 has its chain or range bit set, unit 0 never raises `hit` by itself. Otherwise `hit` is the OR of the two units' matches. Unit 0's own control bits 7:6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | 1 | Unit selected for the write |
| cfg_sel | input | 3 | Register selected for the write |
| cfg_wdata | input | max(AW,DW) | Write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access address |
| acc_data | input | DW | Access data |
| acc_write | input | 1 | 1 write, 0 read |
| acc_size | input | 2 | Access size code |
| acc_is_data | input | 1 | 1 data access, 0 instruction |
| acc_priv | input | 1 | 1 privileged, 0 user |
| acc_ext | input | 1 | External condition |
| seq_clear | input | 1 | Clears the sequence latch |
| hit | output | 1 | Registered watchpoint hit |

## Verification
The embedded properties cover four rules on every cycle:
- an invalid access never produces a hit;
- two disabled units never produce a hit;
- a clear always leaves the sequence latch empty;
- the latch only rises after a valid, uncleared access.

The finer points need the bench's scenarios with a reference model:
- the exact masking arithmetic across all 64 control patterns and every address and data bit;
- the one-cycle lag of register writes;
- the suppression of unit 0 under the chain and range modes;
- the priority of clear over arming.

// File: rtl/wp_pair_match.sv
module wp_pair_match #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic                          cfg_unit,
  input  logic [2:0]                    cfg_sel,
  input  logic [((AW>DW)?AW:DW)-1:0]    cfg_wdata,
  input  logic                          acc_valid,
  input  logic [AW-1:0]                 acc_addr,
  input  logic [DW-1:0]                 acc_data,
  input  logic                          acc_write,
  input  logic [1:0]                    acc_size,
  input  logic                          acc_is_data,
  input  logic                          acc_priv,
  input  logic                          acc_ext,
  input  logic                          seq_clear,
  output logic                          hit
);
  localparam int NU     = 2;
  localparam int FW     = 6;
  localparam int CVW    = 9;
  localparam int CMW    = 8;
  localparam int EN_B   = 8;
  localparam int CHN_B  = 6;
  localparam int RNG_B  = 7;

  logic [AW-1:0]  av_q [NU];
  logic [AW-1:0]  am_q [NU];
  logic [DW-1:0]  dv_q [NU];
  logic [DW-1:0]  dm_q [NU];
  logic [CVW-1:0] cv_q [NU];
  logic [CMW-1:0] cm_q [NU];

  logic [FW-1:0] acc_ctl;
  logic [NU-1:0] cmp, mt;
  logic          armed_q;
  logic          chain1, range1, qual, hit1, hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NU; u++) begin
        av_q[u] <= '0;
        am_q[u] <= '0;
        dv_q[u] <= '0;
        dm_q[u] <= '0;
        cv_q[u] <= '0;
        cm_q[u] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: av_q[cfg_unit] <= cfg_wdata[AW-1:0];
        3'd1: am_q[cfg_unit] <= cfg_wdata[AW-1:0];
        3'd2: dv_q[cfg_unit] <= cfg_wdata[DW-1:0];
        3'd3: dm_q[cfg_unit] <= cfg_wdata[DW-1:0];
        3'd4: cv_q[cfg_unit] <= cfg_wdata[CVW-1:0];
        3'd5: cm_q[cfg_unit] <= cfg_wdata[CMW-1:0];
        default: ;
      endcase
    end
  end

  assign acc_ctl = {acc_ext, acc_priv, acc_is_data, acc_size, acc_write};

  for (genvar u = 0; u < NU; u++) begin : g_unit
    logic a_ok, d_ok, c_ok;
    assign a_ok   = ~|((acc_addr ^ av_q[u]) & ~am_q[u]);
    assign d_ok   = ~|((acc_data ^ dv_q[u]) & ~dm_q[u]);
    assign c_ok   = ~|((acc_ctl ^ cv_q[u][FW-1:0]) & ~cm_q[u][FW-1:0]);
    assign cmp[u] = a_ok & d_ok & c_ok;
    assign mt[u]  = cv_q[u][EN_B] & cmp[u];
  end

  assign chain1 = cv_q[1][CHN_B];
  assign range1 = cv_q[1][RNG_B];
  assign qual   = chain1 | range1;
  assign hit1   = mt[1] & (~chain1 | armed_q) & (~range1 | cmp[0]);
  assign hit_d  = acc_valid & ((mt[0] & ~qual) | hit1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  armed_q <= 1'b0;
    else if (seq_clear)          armed_q <= 1'b0;
    else if (acc_valid && mt[0]) armed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= hit_d;
  end

  // R5
  invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !hit);

  // R3
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cv_q[0][EN_B] && !cv_q[1][EN_B]) |=> !hit);

  // R7
  clear_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear |=> !armed_q);

  // R6
  arm_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(acc_valid) && !$past(seq_clear)));
endmodule

// File: tb/tb_wp_pair_match.sv
`timescale 1ns/1ps
module tb_wp_pair_match;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_unit = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        acc_valid = 0;
  logic [31:0] acc_addr = 0, acc_data = 0;
  logic        acc_write = 0, acc_is_data = 0, acc_priv = 0, acc_ext = 0;
  logic [1:0]  acc_size = 0;
  logic        seq_clear = 0;
  logic        hit;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_av[2], m_am[2], m_dv[2], m_dm[2];
  logic [8:0]  m_cv[2];
  logic [7:0]  m_cm[2];
  logic        m_armed;

  always #4 clk = ~clk;

  wp_pair_match dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_data(acc_data), .acc_write(acc_write),
    .acc_size(acc_size), .acc_is_data(acc_is_data), .acc_priv(acc_priv),
    .acc_ext(acc_ext), .seq_clear(seq_clear), .hit(hit));

  function automatic bit ucmp(int u, logic [31:0] a, logic [31:0] d, logic [5:0] c);
    return (((a ^ m_av[u]) & ~m_am[u]) == 0) && (((d ^ m_dv[u]) & ~m_dm[u]) == 0)
           && (((c ^ m_cv[u][5:0]) & ~m_cm[u][5:0]) == 0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: hit=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive access and optional write, check hit after the edge
  task automatic step(string req, bit v, logic [31:0] a, logic [31:0] d, logic [5:0] c,
                      bit clr = 0, bit we = 0, bit u = 0, logic [2:0] sel = 0,
                      logic [31:0] wd = 0);
    bit m0, m1, c0, ch, rg, e;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_data = d;
    {acc_ext, acc_priv, acc_is_data, acc_size, acc_write} = c;
    seq_clear = clr; cfg_we = we; cfg_unit = u; cfg_sel = sel; cfg_wdata = wd;
    c0 = ucmp(0, a, d, c);
    m0 = m_cv[0][8] && c0;
    m1 = m_cv[1][8] && ucmp(1, a, d, c);
    ch = m_cv[1][6]; rg = m_cv[1][7];
    e  = v && ((m0 && !(ch || rg)) || (m1 && (!ch || m_armed) && (!rg || c0)));
    @(posedge clk); #1;
    check(req, hit, e);
    if (clr) m_armed = 0; else if (v && m0) m_armed = 1;
    if (we) case (sel)
      3'd0: m_av[u] = wd;
      3'd1: m_am[u] = wd;
      3'd2: m_dv[u] = wd;
      3'd3: m_dm[u] = wd;
      3'd4: m_cv[u] = wd[8:0];
      3'd5: m_cm[u] = wd[7:0];
      default: ;
    endcase
    cfg_we = 0; seq_clear = 0; acc_valid = 0;
  endtask

  task automatic wr(bit u, logic [2:0] sel, logic [31:0] wd);
    step("R2", 0, 0, 0, 0, 0, 1, u, sel, wd);
  endtask

  task automatic setunit(bit u, logic [31:0] av, logic [31:0] am, logic [31:0] dv,
                         logic [31:0] dm, logic [8:0] cv, logic [7:0] cm);
    wr(u, 0, av); wr(u, 1, am); wr(u, 2, dv); wr(u, 3, dm);
    wr(u, 4, {23'd0, cv}); wr(u, 5, {24'd0, cm});
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      m_av[u] = 0; m_am[u] = 0; m_dv[u] = 0; m_dm[u] = 0; m_cv[u] = 0; m_cm[u] = 0;
    end
    m_armed = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", hit, 0);
    @(negedge clk) rst_n = 1;
    // R1: registers zero, units disabled: an all-zero access gives no hit
    step("R1", 1, 0, 0, 0);

    // R3 R4: control sweep over values and masks
    for (int vi = 0; vi < 4; vi++)
      for (int mi = 0; mi < 4; mi++) begin
        logic [5:0] vv, mm;
        vv = (vi == 0) ? 6'h00 : (vi == 1) ? 6'h2A : (vi == 2) ? 6'h15 : 6'h3F;
        mm = (mi == 0) ? 6'h00 : (mi == 1) ? 6'h0F : (mi == 2) ? 6'h30 : 6'h3F;
        setunit(0, 32'h1000, 0, 0, 32'hFFFF_FFFF, {3'b100, vv}, {(mi == 1) ? 2'b11 : 2'b00, mm});
        for (int c = 0; c < 64; c++) step("R3", 1, 32'h1000, 32'h55, c[5:0]);
      end

    // R3 R4: address and data per-bit sweeps with partial masks
    setunit(0, 32'hA5C3_0F18, 32'h00FF_00F0, 32'h1234_5678, 32'hF000_000F, 9'h100, 8'h3F);
    for (int b = 0; b < 32; b++) begin
      step("R4 addr", 1, 32'hA5C3_0F18 ^ (32'd1 << b), 32'h1234_5678, 0);
      step("R4 data", 1, 32'hA5C3_0F18, 32'h1234_5678 ^ (32'd1 << b), 0);
    end

    // R4: enable cannot be masked
    setunit(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 9'h000, 8'hFF);
    step("R4 enable", 1, 32'h7, 32'h9, 6'h11);

    // R2: write in same cycle as access uses old contents, unused selects ignored
    step("R2 same-cycle", 1, 32'h7, 32'h9, 0, 0, 1, 0, 4, 32'h100);
    step("R2 next-cycle", 1, 32'h7, 32'h9, 0);
    step("R2 sel6", 1, 0, 0, 0, 0, 1, 0, 6, 32'h0);
    step("R2 sel7", 1, 0, 0, 0, 0, 1, 0, 7, 32'h0);
    step("R2 after sel6/7", 1, 32'h3, 32'h4, 6'h2);

    // R5: invalid access gives no hit
    step("R5 invalid", 0, 32'h7, 32'h9, 0);

    // R9: two units OR together, unit0 bits 7:6 inert
    setunit(0, 32'h10, 0, 0, 32'hFFFF_FFFF, 9'h1C0, 8'h3F);
    setunit(1, 32'h20, 0, 0, 32'hFFFF_FFFF, 9'h100, 8'h3F);
    step("R9 unit0", 1, 32'h10, 0, 0);
    step("R9 unit1", 1, 32'h20, 0, 0);
    step("R9 none", 1, 32'h30, 0, 0);

    // R6 R7: chain mode
    step("R7", 1, 0, 0, 0, 1);
    wr(1, 4, 32'h140);
    step("R6 not armed", 1, 32'h20, 0, 0);
    step("R9 unit0 suppressed", 1, 32'h10, 0, 0, 1);
    step("R7 clear wins", 1, 32'h20, 0, 0);
    step("R5 invalid no arm", 0, 32'h10, 0, 0);
    step("R6 still unarmed", 1, 32'h20, 0, 0);
    step("R6 arm", 1, 32'h10, 0, 0);
    step("R6 armed", 1, 32'h20, 0, 0);
    step("R6 persists", 1, 32'h20, 0, 0);
    step("R7 clear", 0, 0, 0, 0, 1);
    step("R7 after clear", 1, 32'h20, 0, 0);

    // R8: range mode, unit0 disabled, compare on address bit 8
    setunit(0, 32'h100, 32'hFFFF_FEFF, 0, 32'hFFFF_FFFF, 9'h000, 8'h3F);
    setunit(1, 32'h0, 32'h0000_00FF, 0, 32'hFFFF_FFFF, 9'h180, 8'h3F);
    for (int a = 0; a < 512; a += 37) step("R8 range", 1, a, 0, 0);
    wr(0, 4, 32'h100);
    for (int a = 0; a < 512; a += 41) step("R9 range qual", 1, a, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule